// File: doc/BRIEF.md
# Interrupt Source Configuration Register Bank

This block holds two 32-bit configuration words for every interrupt source of a multiprocessor interrupt controller. One is a vector/priority word and the other is a destination word. Software reaches the words over a simple 32-bit register port that has a single-cycle valid/write strobe. The sources live in four separate address windows: external, internal, message and message-signalled. The bank folds these windows into one flat source index space.

Timer and inter-processor sources have no bus window. A side write port, driven by a neighbouring timer block, reaches their entries, so every source shares the same storage. For a source being raised towards CPU 0, the bank also gives a steering decision. The source goes either to the normal interrupt output or to the critical interrupt output, depending on one bit of its destination word.

Top module: `srccfg_bank`

## Requirements
- R1: A request whose address has any of bits 3:0 set is ignored: a write changes no word, and a read returns 0xFFFFFFFF.
- R2: The external window is offsets 0x0000–0x017F, and its base index is 0. The internal window is 0x0200–0x09FF, and its base index is 12. The message-signalled window is 0x1C00–0x1CFF, and its base index is 84. Within a window, the index is the base plus (offset − window start) >> 5. Address bit 4 = 1 selects the destination word, and bit 4 = 0 selects the vector/priority word.
- R3: The message window starts at 0x1600 with base index 80. Only 0x1600–0x167F hold registers (indices 80–83). Requests to 0x1680–0x16FF are ignored: they change no word, and reads return 0xFFFFFFFF.
- R4: A request to any aligned offset outside the windows is ignored, and a read of it returns 0xFFFFFFFF. Examples are 0x0180–0x01FF, 0x0A00–0x15FF and 0x1D00 upward.
- R5: After reset, every vector/priority word is 0x80800000 and every destination word is 0x00000001. The read data output is 0.
- R6: The read data output takes its new value on the clock edge that accepts a read request. It holds that value while no read is requested.
- R7: An accepted write stores all 32 bits of write data into the addressed word, and a later read returns them.
- R8: While raise_valid is high with raise_idx below 96, exactly one output is high. irq_crit_out is high when bit 1 of that source's destination word is set, and irq_norm_out is high otherwise. Both outputs are low while raise_valid is low. The outputs follow combinationally, in the same cycle.
- R9: The side port writes only timer indices (76–79) and inter-processor indices (92–95). side_sel = 1 selects the destination word. Side writes to any other index are ignored.
- R10: The flat index space is ordered as follows: external 0–11, internal 12–75, timer 76–79, message 80–83, message-signalled 84–91, inter-processor 92–95.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request strobe, one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte offset within the source region |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| side_we | input | 1 | Side write strobe from the timer block |
| side_idx | input | 7 | Flat source index for the side write |
| side_sel | input | 1 | 1 = destination word, 0 = vector/priority word |
| side_wdata | input | 32 | Side write data |
| raise_valid | input | 1 | A source is being raised to CPU 0 |
| raise_idx | input | 7 | Flat index of the raised source |
| irq_norm_out | output | 1 | Steered to the normal interrupt output |
| irq_crit_out | output | 1 | Steered to the critical interrupt output |

## Verification
Read data passes through one register. It is therefore due on the first rising edge after the read request is presented. The bench drives every request on a falling edge and samples rsp_rdata on the next falling edge, half a cycle after that capture. A write becomes visible on the edge that accepts it. Steering is combinational, so each raise is checked 1 ns after raise_idx is driven, well clear of any edge. Ignored requests are proven ignored by reading back, or by raising, the entries an aliasing decode would have hit.

// File: rtl/srccfg_pkg.sv
package srccfg_pkg;
  localparam int N_EXT = 12;
  localparam int N_INT = 64;
  localparam int N_TMR = 4;
  localparam int N_MSG = 4;
  localparam int N_MSI = 8;
  localparam int N_IPI = 4;
  localparam int N_SRC = N_EXT + N_INT + N_TMR + N_MSG + N_MSI + N_IPI;
  localparam int IDX_W = $clog2(N_SRC);

  localparam int B_EXT = 0;
  localparam int B_INT = B_EXT + N_EXT;
  localparam int B_TMR = B_INT + N_INT;
  localparam int B_MSG = B_TMR + N_TMR;
  localparam int B_MSI = B_MSG + N_MSG;
  localparam int B_IPI = B_MSI + N_MSI;

  localparam int SLOT_SH  = 5;
  localparam int CRIT_BIT = 1;
  localparam int N_WIN    = 4;

  localparam logic [31:0] VP_RST = 32'h8080_0000;
  localparam logic [31:0] DE_RST = 32'h0000_0001;

  function automatic int win_start(input int w);
    case (w)
      0:       return 32'h0000;
      1:       return 32'h0200;
      2:       return 32'h1600;
      default: return 32'h1C00;
    endcase
  endfunction

  function automatic int win_count(input int w);
    case (w)
      0:       return N_EXT;
      1:       return N_INT;
      2:       return N_MSG;
      default: return N_MSI;
    endcase
  endfunction

  function automatic int win_base(input int w);
    case (w)
      0:       return B_EXT;
      1:       return B_INT;
      2:       return B_MSG;
      default: return B_MSI;
    endcase
  endfunction

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic             sel_de;
  } slot_t;
endpackage

// File: rtl/srccfg_decode.sv
module srccfg_decode
  import srccfg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output slot_t             slot
);
  logic [N_WIN-1:0] in_w;
  logic [IDX_W-1:0] idx_w [N_WIN];
  logic [31:0]      a32;

  assign a32 = 32'(addr);

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    localparam int WS = win_start(w);
    localparam int WE = WS + (win_count(w) << SLOT_SH);
    localparam int WB = win_base(w);
    logic [31:0] rel;
    assign rel      = a32 - 32'(WS);
    assign in_w[w]  = (a32 >= 32'(WS)) && (a32 < 32'(WE));
    assign idx_w[w] = IDX_W'(32'(WB) + (rel >> SLOT_SH));
  end

  always_comb begin
    slot.hit    = (addr[3:0] == 4'h0) && (|in_w);
    slot.sel_de = addr[4];
    slot.idx    = '0;
    for (int w = 0; w < N_WIN; w++) begin
      if (in_w[w]) slot.idx = slot.idx | idx_w[w];
    end
  end

  // R2: decoded index always lies inside the flat space, windows never overlap
  always_comb begin
    if (slot.hit) begin
      a_r2_idx_in_space: assert (32'(slot.idx) < N_SRC);
    end
    a_r2_windows_disjoint: assert ($onehot0(in_w));
  end
endmodule

// File: rtl/srccfg_store.sv
module srccfg_store
  import srccfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [IDX_W-1:0] bus_idx,
  input  logic             bus_sel,
  input  logic [31:0]      bus_wdata,
  input  logic             side_we,
  input  logic [IDX_W-1:0] side_idx,
  input  logic             side_sel,
  input  logic [31:0]      side_wdata,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_vp,
  output logic [31:0]      rd_de,
  input  logic [IDX_W-1:0] steer_idx,
  output logic [31:0]      steer_de
);
  logic [31:0] vp_all [N_SRC];
  logic [31:0] de_all [N_SRC];
  logic        side_ok;

  assign side_ok = side_we &&
                   (((32'(side_idx) >= B_TMR) && (32'(side_idx) < B_TMR + N_TMR)) ||
                    ((32'(side_idx) >= B_IPI) && (32'(side_idx) < B_IPI + N_IPI)));

  for (genvar i = 0; i < N_SRC; i++) begin : g_ent
    logic [31:0] vp_r, de_r, vp_d, de_d;
    logic        vp_en, de_en, hit_b, hit_s;

    assign hit_b = bus_we  && (bus_idx  == IDX_W'(i));
    assign hit_s = side_ok && (side_idx == IDX_W'(i));

    always_comb begin
      vp_en = 1'b0;
      de_en = 1'b0;
      vp_d  = vp_r;
      de_d  = de_r;
      if (hit_b) begin
        if (bus_sel) begin de_en = 1'b1; de_d = bus_wdata; end
        else         begin vp_en = 1'b1; vp_d = bus_wdata; end
      end else if (hit_s) begin
        if (side_sel) begin de_en = 1'b1; de_d = side_wdata; end
        else          begin vp_en = 1'b1; vp_d = side_wdata; end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vp_r <= VP_RST;
      else if (vp_en) vp_r <= vp_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     de_r <= DE_RST;
      else if (de_en) de_r <= de_d;
    end

    assign vp_all[i] = vp_r;
    assign de_all[i] = de_r;
  end

  always_comb begin
    rd_vp    = 32'hFFFF_FFFF;
    rd_de    = 32'hFFFF_FFFF;
    steer_de = 32'h0;
    if (32'(rd_idx) < N_SRC) begin
      rd_vp = vp_all[rd_idx];
      rd_de = de_all[rd_idx];
    end
    if (32'(steer_idx) < N_SRC) steer_de = de_all[steer_idx];
  end

  // R9: a side destination write to a timer index lands on the next edge
  a_r9_side_timer_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (side_we && side_sel && (32'(side_idx) >= B_TMR) && (32'(side_idx) < B_TMR + N_TMR))
    |=> (de_all[$past(side_idx)] == $past(side_wdata)));

  // R9: a side write to an external or internal index leaves the word alone
  a_r9_side_low_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (side_we && side_sel && (32'(side_idx) < B_TMR) && !(bus_we && bus_idx == side_idx))
    |=> (de_all[$past(side_idx)] == $past(de_all[side_idx])));
endmodule

// File: rtl/srccfg_bank.sv
module srccfg_bank
  import srccfg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              side_we,
  input  logic [IDX_W-1:0]  side_idx,
  input  logic              side_sel,
  input  logic [DATA_W-1:0] side_wdata,
  input  logic              raise_valid,
  input  logic [IDX_W-1:0]  raise_idx,
  output logic              irq_norm_out,
  output logic              irq_crit_out
);
  slot_t       slot;
  logic        bus_we, rd_en, raise_ok;
  logic [31:0] rd_vp, rd_de, steer_de, rd_d;

  srccfg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (req_addr),
    .slot (slot)
  );

  assign bus_we = req_valid && req_write && slot.hit;
  assign rd_en  = req_valid && !req_write;

  srccfg_store u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_idx    (slot.idx),
    .bus_sel    (slot.sel_de),
    .bus_wdata  (32'(req_wdata)),
    .side_we    (side_we),
    .side_idx   (side_idx),
    .side_sel   (side_sel),
    .side_wdata (32'(side_wdata)),
    .rd_idx     (slot.idx),
    .rd_vp      (rd_vp),
    .rd_de      (rd_de),
    .steer_idx  (raise_idx),
    .steer_de   (steer_de)
  );

  always_comb begin
    rd_d = 32'hFFFF_FFFF;
    if (slot.hit) rd_d = slot.sel_de ? rd_de : rd_vp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rsp_rdata <= '0;
    else if (rd_en) rsp_rdata <= DATA_W'(rd_d);
  end

  assign raise_ok     = raise_valid && (32'(raise_idx) < N_SRC);
  assign irq_crit_out = raise_ok &&  steer_de[CRIT_BIT];
  assign irq_norm_out = raise_ok && !steer_de[CRIT_BIT];

  // R1: misaligned reads answer all-ones on the next edge
  a_r1_misaligned_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && (req_addr[3:0] != 4'h0)) |=> (rsp_rdata == '1));

  // R4: the gap between the external and internal windows reads all-ones
  a_r4_gap_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && (32'(req_addr) >= 32'h180) && (32'(req_addr) < 32'h200))
    |=> (rsp_rdata == '1));

  // R6: read data holds while no read is requested
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> $stable(rsp_rdata));

  // R8: exactly one output for a valid raise, none otherwise
  a_r8_one_output: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_valid && (32'(raise_idx) < N_SRC)) |-> (irq_norm_out ^ irq_crit_out));

  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !raise_valid |-> (!irq_norm_out && !irq_crit_out));
endmodule

// File: tb/sim_srccfg_bank.sv
`timescale 1ns/1ps
module sim_srccfg_bank;
  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [15:0] req_addr;
  logic [31:0] req_wdata, rsp_rdata;
  logic        side_we, side_sel;
  logic [6:0]  side_idx, raise_idx;
  logic [31:0] side_wdata;
  logic        raise_valid, irq_norm_out, irq_crit_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [31:0] m_vp [96];
  logic [31:0] m_de [96];

  srccfg_bank u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .side_we(side_we), .side_idx(side_idx), .side_sel(side_sel),
    .side_wdata(side_wdata), .raise_valid(raise_valid), .raise_idx(raise_idx),
    .irq_norm_out(irq_norm_out), .irq_crit_out(irq_crit_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int exp_idx(input logic [15:0] a);
    int x;
    x = int'(a);
    if (a[3:0] != 4'h0)                 return -1;
    if (x < 'h180)                      return x >> 5;
    if (x >= 'h200  && x < 'hA00)       return 12 + ((x - 'h200) >> 5);
    if (x >= 'h1600 && x < 'h1680)      return 80 + ((x - 'h1600) >> 5);
    if (x >= 'h1C00 && x < 'h1D00)      return 84 + ((x - 'h1C00) >> 5);
    return -1;
  endfunction

  function automatic logic [31:0] exp_read(input logic [15:0] a);
    int i;
    i = exp_idx(a);
    if (i < 0) return 32'hFFFF_FFFF;
    return a[4] ? m_de[i] : m_vp[i];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    int i;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    i = exp_idx(a);
    if (i >= 0) begin
      if (a[4]) m_de[i] = d; else m_vp[i] = d;
    end
  endtask

  task automatic bus_read(input logic [15:0] a, input string req);
    logic [31:0] e;
    e = exp_read(a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    chk(rsp_rdata === e, req, rsp_rdata, e);
    req_valid = 1'b0;
  endtask

  task automatic side_write(input int i, input bit sel, input logic [31:0] d);
    @(negedge clk);
    side_we = 1'b1; side_idx = 7'(i); side_sel = sel; side_wdata = d;
    @(negedge clk);
    side_we = 1'b0;
    if ((i >= 76 && i < 80) || (i >= 92 && i < 96)) begin
      if (sel) m_de[i] = d; else m_vp[i] = d;
    end
  endtask

  task automatic raise_chk(input int i, input string req);
    bit c;
    @(negedge clk);
    raise_valid = 1'b1; raise_idx = 7'(i);
    #1;
    c = m_de[i][1];
    chk((irq_crit_out === c) && (irq_norm_out === !c), req,
        {30'b0, irq_crit_out, irq_norm_out}, {30'b0, c, !c});
    raise_valid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold;
    void'($urandom(32'd1357));
    for (int i = 0; i < 96; i++) begin m_vp[i] = 32'h8080_0000; m_de[i] = 32'h1; end
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    side_we = 0; side_idx = 0; side_sel = 0; side_wdata = 0;
    raise_valid = 0; raise_idx = 0;
    repeat (3) @(negedge clk);
    chk(rsp_rdata === 32'h0, "R5 read data at reset", rsp_rdata, 32'h0);
    rst_n = 1'b1;

    // R5 reset contents across windows
    bus_read(16'h0000, "R5 ext0 vp reset");
    bus_read(16'h0010, "R5 ext0 de reset");
    bus_read(16'h09F0, "R5 int last de reset");
    bus_read(16'h1CE0, "R5 msi last vp reset");
    raise_chk(5, "R8 reset steers normal");

    // R6 hold while idle
    hold = rsp_rdata;
    repeat (3) @(negedge clk);
    chk(rsp_rdata === hold, "R6 hold while idle", rsp_rdata, hold);

    // R2 / R7 / R10 directed
    bus_write(16'h0210, 32'h0000_0002);
    raise_chk(12, "R10 internal base index 12 critical");
    bus_write(16'h0160, 32'hDEAD_BEEF);
    bus_read(16'h0160, "R7 ext11 vp full word");
    bus_read(16'h0170, "R2 ext11 de untouched by vp write");
    bus_write(16'h1610, 32'h4000_0002);
    raise_chk(80, "R10 message base index 80");
    bus_write(16'h1CF0, 32'h0000_0002);
    raise_chk(91, "R10 msi last index 91");
    bus_write(16'h1C10, 32'h1234_5678);
    bus_read(16'h1C10, "R2 msi first de");

    // R3 upper message half ignored, no alias into msi 84
    bus_write(16'h1690, 32'h0000_0002);
    bus_read(16'h1690, "R3 upper message half reads ones");
    bus_read(16'h1C10, "R3 msi84 not aliased");
    raise_chk(84, "R3 msi84 steering unchanged");

    // R1 misaligned
    bus_write(16'h0014, 32'h0000_0002);
    bus_read(16'h0010, "R1 misaligned write ignored");
    bus_read(16'h0014, "R1 misaligned read ones");
    raise_chk(0, "R1 steering unchanged");

    // R4 out of window
    bus_read(16'h0180, "R4 gap reads ones");
    bus_read(16'h0A00, "R4 above internal reads ones");
    bus_write(16'h1D10, 32'h0000_0002);
    bus_read(16'h1D10, "R4 above msi reads ones");

    // R9 side port
    side_write(76, 1'b1, 32'h0000_0002);
    raise_chk(76, "R9 timer side write critical");
    side_write(95, 1'b1, 32'h0000_0002);
    raise_chk(95, "R9 ipi side write critical");
    side_write(5, 1'b1, 32'h0000_0002);
    bus_read(16'h00B0, "R9 side write to ext ignored");
    raise_chk(5, "R9 ext steering unchanged");

    // random mix
    for (int n = 0; n < 800; n++) begin
      logic [15:0] a;
      int kind;
      kind = int'($urandom % 6);
      case (kind)
        0: a = 16'($urandom % 'h200);
        1: a = 16'('h200 + ($urandom % 'h840));
        2: a = 16'('h1600 + ($urandom % 'h100));
        3: a = 16'('h1C00 + ($urandom % 'h120));
        default: a = 16'($urandom);
      endcase
      if (($urandom % 8) != 0) a[3:0] = 4'h0;
      case ($urandom % 4)
        0: bus_write(a, (($urandom % 2) == 0) ? 32'($urandom) : 32'($urandom % 4));
        1: bus_read(a, "R2 R7 random read");
        2: side_write(int'($urandom % 96), 1'($urandom), 32'($urandom % 4));
        default: raise_chk(int'($urandom % 96), "R8 random steering");
      endcase
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule